// File: doc/BRIEF.md
# Timer Clock Source Selector

This block sits in front of the prescaler of a 16-bit timer and decides when the timer may advance. Software picks one of four sources through a 2-bit select field, and the block turns that choice into a count-enable strobe. The strobe is one bus cycle wide and is aligned to the bus clock. The choices are:

- no source, which freezes the counter;
- the bus clock itself, which enables every cycle;
- a fixed-rate clock;
- an asynchronous external pin.

The fixed-rate clock is handled in one of two ways:

- With the PLL flag low, the fixed-rate input is already a bus-synchronous enable and is passed through directly.
- With the flag high, it is treated as a foreign clock waveform. It goes through a synchronizer, and each of its rising edges yields one strobe.

The external pin is always synchronized and edge-detected. For every rising edge to be caught, the pin must toggle no faster than a quarter of the bus rate. When the effective source changes, the edge history is reloaded from the new source in the same cycle. A level that is already high on the new source is therefore never taken as an edge.

Top module: `tmr_clk_sel`

## Requirements
- R1: While rst_ni is low, cnt_en_o is low and the synchronizer stages are cleared.
- R2: With src_sel_i = 2'b00, cnt_en_o is low one cycle later, whatever fix_clk_i and ext_clk_i do.
- R3: With src_sel_i = 2'b01, cnt_en_o is high in the cycle after every clock edge at which that code is present.
- R4: With src_sel_i = 2'b10 and pll_on_i low, cnt_en_o after edge n equals fix_clk_i sampled at edge n.
- R5: With src_sel_i = 2'b10 and pll_on_i high, suppose fix_clk_i is low at edge n-1 and high at edge n. Then cnt_en_o is high for one cycle after edge n+2.
- R6: With src_sel_i = 2'b11, ext_clk_i is edge-detected with the same two-stage latency as R5, whatever the value of pll_on_i.
- R7: On a synchronized path a strobe lasts exactly one cycle. An external clock with each level held for at least two bus cycles produces exactly one strobe per rising edge.
- R8: In the first cycle after the effective source changes (a new src_sel_i, or pll_on_i toggling while src_sel_i = 2'b10), no strobe is produced for a synchronized path, even if the new source is already high.
- R9: A falling edge on a synchronized source never produces a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 2 | Source select: 00 off, 01 bus, 10 fixed-rate, 11 external pin |
| pll_on_i | input | 1 | High when the fixed-rate clock is asynchronous to the bus clock |
| fix_clk_i | input | 1 | Fixed-rate clock or enable |
| ext_clk_i | input | 1 | External clock pin, asynchronous |
| cnt_en_o | output | 1 | One-cycle count-enable strobe to the prescaler |

## Verification
The results arrive at different times:
- The off, bus and direct fixed-rate results appear one edge after the select and input values are sampled.
- A rising edge on a synchronized source shows up after the second edge that follows the edge that first sampled it.
- The source-change suppression acts on the first edge at which the new select is seen.

The bench keeps its own four-deep history of sampled inputs and the previous effective source, and from these predicts the strobe after each rising edge. It compares at the following falling edge, so every check lands on the cycle in which the registered output is valid. Pulse-count windows for the quarter-rate external clock and the falling-only case are closed several cycles after the last stimulus, so that the two-stage pipeline has fully drained.

// File: rtl/tmr_clk_pkg.sv
package tmr_clk_pkg;

  typedef enum logic [1:0] {
    SRC_OFF = 2'b00,
    SRC_BUS = 2'b01,
    SRC_FIX = 2'b10,
    SRC_EXT = 2'b11
  } src_sel_e;

  typedef enum logic [2:0] {
    PATH_NONE,
    PATH_BUS,
    PATH_FIX_DIR,
    PATH_FIX_SYNC,
    PATH_EXT_SYNC
  } path_e;

  localparam int unsigned N_ASYNC = 2;
  localparam int unsigned FIX_IDX = 0;
  localparam int unsigned EXT_IDX = 1;

  function automatic path_e decode_path(src_sel_e sel, logic pll_on);
    path_e p;
    unique case (sel)
      SRC_OFF: p = PATH_NONE;
      SRC_BUS: p = PATH_BUS;
      SRC_FIX: p = pll_on ? PATH_FIX_SYNC : PATH_FIX_DIR;
      SRC_EXT: p = PATH_EXT_SYNC;
      default: p = PATH_NONE;
    endcase
    return p;
  endfunction

  function automatic logic path_is_sync(path_e p);
    return (p == PATH_FIX_SYNC) || (p == PATH_EXT_SYNC);
  endfunction

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= '0;
      else         stg_q <= d_i;
    end
  end else begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= '0;
      else         stg_q <= {stg_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic reload_i,
  output logic rise_o
);
  logic hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= 1'b0;
    else         hist_q <= lvl_i;
  end

  // reload: history belongs to the old source, so no edge this cycle
  assign rise_o = lvl_i & ~hist_q & ~reload_i;
endmodule

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
  import tmr_clk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] src_sel_i,
  input  logic       pll_on_i,
  input  logic       fix_clk_i,
  input  logic       ext_clk_i,
  output logic       cnt_en_o
);
  logic [N_ASYNC-1:0] async_raw;
  logic [N_ASYNC-1:0] async_sync;
  path_e              path_d, path_q;
  logic               path_chg;
  logic               sync_lvl;
  logic               rise;
  logic               en_d;

  assign async_raw[FIX_IDX] = fix_clk_i;
  assign async_raw[EXT_IDX] = ext_clk_i;

  for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
    tmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (async_raw[g]),
      .q_o   (async_sync[g])
    );
  end

  always_comb path_d = decode_path(src_sel_e'(src_sel_i), pll_on_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) path_q <= PATH_NONE;
    else         path_q <= path_d;
  end

  assign path_chg = (path_d != path_q);

  always_comb begin
    unique case (path_d)
      PATH_FIX_SYNC: sync_lvl = async_sync[FIX_IDX];
      PATH_EXT_SYNC: sync_lvl = async_sync[EXT_IDX];
      default:       sync_lvl = 1'b0;
    endcase
  end

  tmr_edge_det u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (sync_lvl),
    .reload_i(path_chg),
    .rise_o  (rise)
  );

  always_comb begin
    unique case (path_d)
      PATH_NONE:     en_d = 1'b0;
      PATH_BUS:      en_d = 1'b1;
      PATH_FIX_DIR:  en_d = fix_clk_i;
      PATH_FIX_SYNC,
      PATH_EXT_SYNC: en_d = rise;
      default:       en_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_en_o <= 1'b0;
    else         cnt_en_o <= en_d;
  end
endmodule

// File: rtl/tmr_clk_sel_chk.sv
module tmr_clk_sel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] src_sel_i,
  input logic       pll_on_i,
  input logic       fix_clk_i,
  input logic       ext_clk_i,
  input logic       cnt_en_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_low_R1: assert (cnt_en_o == 1'b0);
    end
  end

  assert_off_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == 2'b00) |=> !cnt_en_o);

  assert_bus_every_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == 2'b01) |=> cnt_en_o);

  assert_fix_direct_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == 2'b10 && !pll_on_i) |=> (cnt_en_o == $past(fix_clk_i)));

  assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_o && (src_sel_i == 2'b11 || (src_sel_i == 2'b10 && pll_on_i)))
    |=> !cnt_en_o);

  assert_switch_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == 2'b11 && $past(src_sel_i) != 2'b11) |=> !cnt_en_o);

  assert_no_ext_activity_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == 2'b11 && $stable(ext_clk_i) && $past(src_sel_i) == 2'b11
     && !$past(cnt_en_o) && !cnt_en_o && $past(ext_clk_i) == ext_clk_i && ext_clk_i == 1'b0
     && $past(ext_clk_i, 2) == 1'b0) |=> !cnt_en_o);
endmodule

bind tmr_clk_sel tmr_clk_sel_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .src_sel_i(src_sel_i),
  .pll_on_i (pll_on_i),
  .fix_clk_i(fix_clk_i),
  .ext_clk_i(ext_clk_i),
  .cnt_en_o (cnt_en_o)
);

// File: tb/test_tmr_clk_sel.sv
`timescale 1ns/1ps
module test_tmr_clk_sel;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic [1:0] src_sel_i = 2'b00;
  logic       pll_on_i = 1'b0;
  logic       fix_clk_i = 1'b0;
  logic       ext_clk_i = 1'b0;
  logic       cnt_en_o;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  int pulse_cnt = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  tmr_clk_sel i_tmr_clk_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_sel_i(src_sel_i),
    .pll_on_i (pll_on_i),
    .fix_clk_i(fix_clk_i),
    .ext_clk_i(ext_clk_i),
    .cnt_en_o (cnt_en_o)
  );

  task automatic check_bit(logic got, logic exp, string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: cnt_en_o=%0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_int(int got, int exp, string tag);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: pulse count=%0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // effective source codes: 0 off, 1 bus, 2 fixed direct, 3 fixed sync, 4 external sync
  function automatic int src_code(logic [1:0] sel, logic pll);
    case (sel)
      2'b00:   return 0;
      2'b01:   return 1;
      2'b10:   return pll ? 3 : 2;
      default: return 4;
    endcase
  endfunction

  function automatic logic predict(int code, bit chg, logic fix_now,
                                   logic [3:0] fh, logic [3:0] eh);
    case (code)
      0:       return 1'b0;
      1:       return 1'b1;
      2:       return fix_now;
      3:       return chg ? 1'b0 : (fh[2] & ~fh[3]);
      default: return chg ? 1'b0 : (eh[2] & ~eh[3]);
    endcase
  endfunction

  function automatic string tag_of(int code, bit chg);
    case (code)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return chg ? "R8" : "R5";
      default: return chg ? "R8" : "R6";
    endcase
  endfunction

  logic [3:0] fix_hist = '0;
  logic [3:0] ext_hist = '0;
  int         prev_code = 0;
  logic       exp_q = 1'b0;
  string      exp_tag = "R1";
  bit         model_ok = 1'b0;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      fix_hist  <= '0;
      ext_hist  <= '0;
      prev_code <= 0;
      model_ok  <= 1'b0;
    end else begin
      logic [3:0] fh, eh;
      int c;
      bit chg;
      fh = {fix_hist[2:0], fix_clk_i};
      eh = {ext_hist[2:0], ext_clk_i};
      c = src_code(src_sel_i, pll_on_i);
      chg = (c != prev_code);
      exp_q     <= predict(c, chg, fix_clk_i, fh, eh);
      exp_tag   <= tag_of(c, chg);
      fix_hist  <= fh;
      ext_hist  <= eh;
      prev_code <= c;
      model_ok  <= 1'b1;
    end
  end

  always @(negedge clk_i) begin
    if (model_ok && rst_ni && !done) begin
      check_bit(cnt_en_o, exp_q, exp_tag);
      if (cnt_en_o) pulse_cnt++;
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles == 150000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected fewer than %0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    void'($urandom(32'd4242));
    #1 rst_ni = 1'b0;
    src_sel_i = 2'b01;
    ext_clk_i = 1'b1;
    fix_clk_i = 1'b1;
    // R1: output low throughout reset even with bus source selected
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      check_bit(cnt_en_o, 1'b0, "R1");
    end
    src_sel_i = 2'b00;
    ext_clk_i = 1'b0;
    fix_clk_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2: off, inputs toggling
    for (int i = 0; i < 12; i++) begin
      @(negedge clk_i);
      fix_clk_i = 1'($urandom);
      ext_clk_i = 1'($urandom);
    end
    // R3: bus
    src_sel_i = 2'b01;
    step(8);
    // R4: fixed direct
    src_sel_i = 2'b10;
    pll_on_i  = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i);
      fix_clk_i = 1'($urandom);
    end
    // R5: fixed synchronized
    pll_on_i = 1'b1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk_i);
      fix_clk_i = (i % 4) < 2;
    end
    // R6 / R7: external at quarter rate, 10 rising edges
    src_sel_i = 2'b11;
    ext_clk_i = 1'b0;
    fix_clk_i = 1'b0;
    step(5);
    pulse_cnt = 0;
    for (int i = 0; i < 40; i++) begin
      ext_clk_i = (i % 4) < 2;
      @(negedge clk_i);
    end
    ext_clk_i = 1'b0;
    step(6);
    check_int(pulse_cnt, 10, "R7");
    // R9: falling edge only
    ext_clk_i = 1'b1;
    step(6);
    pulse_cnt = 0;
    ext_clk_i = 1'b0;
    step(6);
    check_int(pulse_cnt, 0, "R9");
    // R8: switch into external while pin already high
    src_sel_i = 2'b00;
    ext_clk_i = 1'b1;
    step(5);
    pulse_cnt = 0;
    src_sel_i = 2'b11;
    step(6);
    check_int(pulse_cnt, 0, "R8");
    // R8: pll flag toggles with fixed source high
    src_sel_i = 2'b10;
    pll_on_i  = 1'b0;
    fix_clk_i = 1'b1;
    step(4);
    pll_on_i = 1'b1;
    @(negedge clk_i);
    pulse_cnt = 0;
    step(5);
    check_int(pulse_cnt, 0, "R8");

    // constrained random mix, checked cycle by cycle against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk_i);
      if ($urandom_range(15) == 0) src_sel_i = 2'($urandom);
      if ($urandom_range(31) == 0) pll_on_i = ~pll_on_i;
      if ($urandom_range(2) == 0) fix_clk_i = ~fix_clk_i;
      if ($urandom_range(2) == 0) ext_clk_i = ~ext_clk_i;
    end
    step(4);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule